// File: doc/BRIEF.md
# PLL Divisor Search Engine

This block finds the feedback divisor M and the post divisor P1 that bring a PLL output closest to a requested pixel clock. A host pulses a start strobe with a target frequency in kHz and the core clock frequency in MHz. The engine then walks through every allowed (M, P1) pair, one pair per clock cycle. It keeps the pair whose output lies nearest to the target, and it reports the chosen divisors, the frequency they give, and two ready-made words: a divisor word and a PLL control word.

The core frequency sets the reference clock in kHz (the core MHz value times 1000). It also selects a fixed range for each divisor. Each candidate output is the reference clock times M, divided by 14 times P1, with the quotient truncated. The best candidate is kept only when it is strictly closer than the current best, so the first candidate in the walk wins a tie. A core frequency that has no range ends the run at once and raises an error flag.

Top module: `pll_div_search`

## Requirements
- R1: Each candidate frequency is floor(core_mhz × 1000 × M / (14 × P1)) in kHz, and `dot_khz_o` reports this value for the chosen pair.
- R2: The divisor ranges are inclusive. Core 100 uses M 20..34 with P1 2..8. Core 166 uses M 12..20 with P1 2..7. Core 200 uses M 10..17 with P1 2..8.
- R3: The walk steps P1 upward inside each M and steps M upward across the range. A candidate replaces the best only when its absolute error is strictly smaller, so on a tie the earlier candidate stays.
- R4: The best error starts equal to the target, and the stored result starts at zero. `ok_o` is high exactly when the final best error differs from the target. If no candidate improves on the start, M, P1 and the frequency read zero.
- R5: The divisor word holds a 6-bit code for M at bits [13:8], and all other bits are zero. Codes for M = 10 upward are 2B 15 2A 35 1A 0D 26 33 19 2C 36 3B 1D 2E 37 1B 2D 16 0B 25 12 09 24 32 39 1C (hex). When M is zero the word is zero.
- R6: The control word has only bit 17 + (P1 − 2) set. It is all zero when P1 is zero.
- R7: A core frequency other than 100, 166 or 200 ends the run on the edge that samples start. That run gives `bad_sel_o` high, `ok_o` low and all results zero.
- R8: A valid run with N candidates raises `done_o` on the N+1-th rising edge, counting the edge that samples start as the first. `busy_o` is high during the walk and is never high together with `done_o`. A start pulse during the walk is ignored.
- R9: While `done_o` is high and no start arrives, `done_o` and all results hold steady.
- R10: After reset, `busy_o`, `done_o`, `ok_o` and `bad_sel_o` are low and all results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, sampled when not busy |
| target_khz_i | input | TGT_W | Requested pixel clock in kHz |
| core_mhz_i | input | 8 | Core clock frequency in MHz (range selector) |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Result valid, held until next start |
| ok_o | output | 1 | A candidate improved on the starting error |
| bad_sel_o | output | 1 | Unsupported core frequency |
| m_o | output | 6 | Chosen feedback divisor |
| p1_o | output | 4 | Chosen post divisor |
| dot_khz_o | output | 24 | Output frequency of the chosen pair in kHz |
| div_word_o | output | 32 | Encoded divisor word |
| ctl_word_o | output | 32 | Encoded PLL control word |

## Verification
The time a result takes depends only on the core frequency. For a supported frequency it is the candidate count plus one rising edges after the start edge: 106 edges for core 100, 55 for core 166 and 57 for core 200. For an unsupported frequency it is a single edge. The bench raises start at a falling edge and then counts rising edges, checking `done_o` at each following falling edge. It compares the measured count with the count it derives from the ranges, and only then compares the results with its own model of the walk. After each run it waits a few more cycles and reads the results again, which confirms they hold. One run sends a second start pulse while the walk is in progress and expects both the first run's result and the first run's latency.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    localparam int MHZ_W    = 8;
    localparam int M_W      = 6;
    localparam int P_W      = 4;
    localparam int REF_W    = 18;
    localparam int PROD_W   = REF_W + M_W;
    localparam int DEN_W    = 7;
    localparam int WORD_W   = 32;
    localparam int CODE_W   = 6;
    localparam int CODE_LSB = 8;
    localparam int P1_LSB   = 17;
    localparam int M_BASE   = 10;
    localparam int M_CODES  = 26;
    localparam int P1_BASE  = 2;
    localparam int P1_TOP   = 8;
    localparam int POST_K   = 14;

    typedef struct packed {
        logic [M_W-1:0]   m_lo;
        logic [M_W-1:0]   m_hi;
        logic [P_W-1:0]   p_lo;
        logic [P_W-1:0]   p_hi;
        logic [REF_W-1:0] ref_khz;
        logic             valid;
    } lim_t;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [P_W-1:0] p1;
    } cand_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } st_t;

    // Range set for one core frequency; valid low for unsupported values.
    function automatic lim_t lim_lookup(input logic [MHZ_W-1:0] mhz);
        lim_t r;
        r = '0;
        case (mhz)
            8'd100: begin
                r.m_lo = 6'd20; r.m_hi = 6'd34; r.p_lo = 4'd2; r.p_hi = 4'd8; r.valid = 1'b1;
            end
            8'd166: begin
                r.m_lo = 6'd12; r.m_hi = 6'd20; r.p_lo = 4'd2; r.p_hi = 4'd7; r.valid = 1'b1;
            end
            8'd200: begin
                r.m_lo = 6'd10; r.m_hi = 6'd17; r.p_lo = 4'd2; r.p_hi = 4'd8; r.valid = 1'b1;
            end
            default: r.valid = 1'b0;
        endcase
        if (r.valid) begin
            r.ref_khz = REF_W'(int'(mhz) * 1000);
        end
        return r;
    endfunction

    // Feedback divisor code, keyed by the absolute M value.
    function automatic logic [CODE_W-1:0] m_code(input logic [M_W-1:0] m);
        logic [CODE_W-1:0] c;
        case (m)
            6'd10: c = 6'h2B;  6'd11: c = 6'h15;  6'd12: c = 6'h2A;  6'd13: c = 6'h35;
            6'd14: c = 6'h1A;  6'd15: c = 6'h0D;  6'd16: c = 6'h26;  6'd17: c = 6'h33;
            6'd18: c = 6'h19;  6'd19: c = 6'h2C;  6'd20: c = 6'h36;  6'd21: c = 6'h3B;
            6'd22: c = 6'h1D;  6'd23: c = 6'h2E;  6'd24: c = 6'h37;  6'd25: c = 6'h1B;
            6'd26: c = 6'h2D;  6'd27: c = 6'h16;  6'd28: c = 6'h0B;  6'd29: c = 6'h25;
            6'd30: c = 6'h12;  6'd31: c = 6'h09;  6'd32: c = 6'h24;  6'd33: c = 6'h32;
            6'd34: c = 6'h39;  6'd35: c = 6'h1C;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pll_limit_rom.sv
module pll_limit_rom
    import pll_search_pkg::*;
(
    input  logic [MHZ_W-1:0] core_mhz,
    output lim_t             lim
);
    always_comb begin
        lim = lim_lookup(core_mhz);
    end
endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval
    import pll_search_pkg::*;
#(
    parameter int TGT_W = 20,
    parameter int ERR_W = ((TGT_W > PROD_W) ? TGT_W : PROD_W) + 1
) (
    input  logic [REF_W-1:0]  ref_khz,
    input  cand_t             cand,
    input  logic [TGT_W-1:0]  target,
    output logic [PROD_W-1:0] dot,
    output logic [ERR_W-1:0]  err
);
    logic [PROD_W-1:0] prod;
    logic [DEN_W-1:0]  den;
    logic [ERR_W-1:0]  a_w;
    logic [ERR_W-1:0]  b_w;

    always_comb begin
        prod = PROD_W'(ref_khz) * PROD_W'(cand.m);
        den  = DEN_W'(POST_K) * DEN_W'(cand.p1);
        if (den == '0) begin
            dot = '0;
        end else begin
            dot = prod / PROD_W'(den);
        end
        a_w = ERR_W'(dot);
        b_w = ERR_W'(target);
        err = (a_w >= b_w) ? (a_w - b_w) : (b_w - a_w);
    end
endmodule

// File: rtl/pll_word_enc.sv
module pll_word_enc
    import pll_search_pkg::*;
(
    input  logic [M_W-1:0]    m,
    input  logic [P_W-1:0]    p1,
    output logic [WORD_W-1:0] div_word,
    output logic [WORD_W-1:0] ctl_word
);
    always_comb begin
        div_word = '0;
        if ((int'(m) >= M_BASE) && (int'(m) < M_BASE + M_CODES)) begin
            div_word[CODE_LSB +: CODE_W] = m_code(m);
        end
    end

    for (genvar b = 0; b < WORD_W; b++) begin : g_ctl
        if ((b >= P1_LSB) && (b <= P1_LSB + P1_TOP - P1_BASE)) begin : g_hot
            assign ctl_word[b] = (p1 == P_W'(b - P1_LSB + P1_BASE));
        end else begin : g_zero
            assign ctl_word[b] = 1'b0;
        end
    end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int TGT_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [TGT_W-1:0]  target_khz_i,
    input  logic [MHZ_W-1:0]  core_mhz_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ok_o,
    output logic              bad_sel_o,
    output logic [M_W-1:0]    m_o,
    output logic [P_W-1:0]    p1_o,
    output logic [PROD_W-1:0] dot_khz_o,
    output logic [WORD_W-1:0] div_word_o,
    output logic [WORD_W-1:0] ctl_word_o
);
    localparam int ERR_W = ((TGT_W > PROD_W) ? TGT_W : PROD_W) + 1;

    st_t               state;
    lim_t              lim_w;
    lim_t              lim_q;
    logic [TGT_W-1:0]  tgt_q;
    cand_t             cur;
    cand_t             best;
    logic [PROD_W-1:0] best_dot;
    logic [ERR_W-1:0]  best_err;
    logic              ok_q;
    logic              bad_q;

    logic [PROD_W-1:0] dot_w;
    logic [ERR_W-1:0]  err_w;
    logic              improve;
    logic              last;
    logic [ERR_W-1:0]  nxt_err;

    pll_limit_rom u_rom (
        .core_mhz (core_mhz_i),
        .lim      (lim_w)
    );

    pll_cand_eval #(.TGT_W(TGT_W), .ERR_W(ERR_W)) u_eval (
        .ref_khz (lim_q.ref_khz),
        .cand    (cur),
        .target  (tgt_q),
        .dot     (dot_w),
        .err     (err_w)
    );

    pll_word_enc u_enc (
        .m        (best.m),
        .p1       (best.p1),
        .div_word (div_word_o),
        .ctl_word (ctl_word_o)
    );

    always_comb begin
        improve = (err_w < best_err);
        nxt_err = improve ? err_w : best_err;
        last    = (cur.m == lim_q.m_hi) && (cur.p1 == lim_q.p_hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            lim_q    <= '0;
            tgt_q    <= '0;
            cur      <= '0;
            best     <= '0;
            best_dot <= '0;
            best_err <= '0;
            ok_q     <= 1'b0;
            bad_q    <= 1'b0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (improve) begin
                        best     <= cur;
                        best_dot <= dot_w;
                        best_err <= err_w;
                    end
                    if (last) begin
                        state <= ST_DONE;
                        ok_q  <= (nxt_err != ERR_W'(tgt_q));
                    end else if (cur.p1 == lim_q.p_hi) begin
                        cur.m  <= cur.m + 1'b1;
                        cur.p1 <= lim_q.p_lo;
                    end else begin
                        cur.p1 <= cur.p1 + 1'b1;
                    end
                end
                default: begin
                    if (start_i) begin
                        lim_q    <= lim_w;
                        tgt_q    <= target_khz_i;
                        cur.m    <= lim_w.m_lo;
                        cur.p1   <= lim_w.p_lo;
                        best     <= '0;
                        best_dot <= '0;
                        best_err <= ERR_W'(target_khz_i);
                        ok_q     <= 1'b0;
                        bad_q    <= ~lim_w.valid;
                        state    <= lim_w.valid ? ST_RUN : ST_DONE;
                    end
                end
            endcase
        end
    end

    assign busy_o    = (state == ST_RUN);
    assign done_o    = (state == ST_DONE);
    assign ok_o      = ok_q;
    assign bad_sel_o = bad_q;
    assign m_o       = best.m;
    assign p1_o      = best.p1;
    assign dot_khz_o = best_dot;
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk
    import pll_search_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              ok_o,
    input logic              bad_sel_o,
    input logic [M_W-1:0]    m_o,
    input logic [P_W-1:0]    p1_o,
    input logic [PROD_W-1:0] dot_khz_o,
    input logic [WORD_W-1:0] ctl_word_o
);
    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(m_o) && $stable(p1_o)
                                  && $stable(dot_khz_o) && $stable(ok_o)));

    // R6
    ctl_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctl_word_o));

    // R7
    bad_sel_clean_chk: assert property (@(posedge clk) disable iff (rst)
        bad_sel_o |-> (!ok_o && m_o == '0 && p1_o == '0));

    // R2
    p1_range_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && ok_o) |-> (p1_o >= P_W'(P1_BASE) && p1_o <= P_W'(P1_TOP) && m_o >= M_W'(M_BASE)));
endmodule

bind pll_div_search pll_div_search_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ok_o       (ok_o),
    .bad_sel_o  (bad_sel_o),
    .m_o        (m_o),
    .p1_o       (p1_o),
    .dot_khz_o  (dot_khz_o),
    .ctl_word_o (ctl_word_o)
);

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [19:0] target_khz_i = '0;
    logic [7:0]  core_mhz_i = '0;
    logic        busy_o, done_o, ok_o, bad_sel_o;
    logic [5:0]  m_o;
    logic [3:0]  p1_o;
    logic [23:0] dot_khz_o;
    logic [31:0] div_word_o, ctl_word_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pll_div_search #(.TGT_W(20)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .target_khz_i(target_khz_i),
        .core_mhz_i(core_mhz_i), .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o),
        .bad_sel_o(bad_sel_o), .m_o(m_o), .p1_o(p1_o), .dot_khz_o(dot_khz_o),
        .div_word_o(div_word_o), .ctl_word_o(ctl_word_o)
    );

    task automatic check(input bit pass, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!pass) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    function automatic int code_of(input int m);
        case (m)
            10: return 'h2B; 11: return 'h15; 12: return 'h2A; 13: return 'h35;
            14: return 'h1A; 15: return 'h0D; 16: return 'h26; 17: return 'h33;
            18: return 'h19; 19: return 'h2C; 20: return 'h36; 21: return 'h3B;
            22: return 'h1D; 23: return 'h2E; 24: return 'h37; 25: return 'h1B;
            26: return 'h2D; 27: return 'h16; 28: return 'h0B; 29: return 'h25;
            30: return 'h12; 31: return 'h09; 32: return 'h24; 33: return 'h32;
            34: return 'h39; 35: return 'h1C;
            default: return 0;
        endcase
    endfunction

    // Model of the walk built from R1-style formula, ranges (R2) and tie rule (R3).
    function automatic void model(input int tgt, input int mhz,
                                  output int em, output int ep, output int edot,
                                  output bit eok, output bit evalid, output int ncand);
        int mlo, mhi, plo, phi, berr;
        evalid = 1'b1;
        mlo = 0; mhi = 0; plo = 0; phi = 0;
        case (mhz)
            100: begin mlo = 20; mhi = 34; plo = 2; phi = 8; end
            166: begin mlo = 12; mhi = 20; plo = 2; phi = 7; end
            200: begin mlo = 10; mhi = 17; plo = 2; phi = 8; end
            default: evalid = 1'b0;
        endcase
        em = 0; ep = 0; edot = 0; berr = tgt; ncand = 0;
        if (evalid) begin
            for (int m = mlo; m <= mhi; m++) begin
                for (int p = plo; p <= phi; p++) begin
                    int d, e;
                    d = (mhz * 1000 * m) / (14 * p);
                    e = (d >= tgt) ? d - tgt : tgt - d;
                    ncand++;
                    if (e < berr) begin
                        berr = e; em = m; ep = p; edot = d;
                    end
                end
            end
        end
        eok = evalid && (berr != tgt);
    endfunction

    task automatic run_case(input int tgt, input int mhz, input bit poke_busy);
        int em, ep, edot, ncand, cnt, exp_lat;
        bit eok, evalid;
        longint exp_div, exp_ctl;
        model(tgt, mhz, em, ep, edot, eok, evalid, ncand);
        @(negedge clk);
        start_i = 1'b1;
        target_khz_i = 20'(tgt);
        core_mhz_i = 8'(mhz);
        @(posedge clk);
        cnt = 1;
        @(negedge clk);
        start_i = 1'b0;
        if (evalid) begin
            check(busy_o === 1'b1, "R8", "busy after start", longint'(busy_o), 1);
        end
        while (!done_o && cnt < 400) begin
            if (poke_busy && cnt == 10) begin
                start_i = 1'b1;
                target_khz_i = 20'd5;
                core_mhz_i = 8'd7;
            end else begin
                start_i = 1'b0;
            end
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end
        start_i = 1'b0;
        exp_lat = evalid ? ncand + 1 : 1;
        check(cnt == exp_lat, evalid ? "R8" : "R7", "latency", cnt, exp_lat);
        check(m_o == 6'(em), "R3", "M", m_o, em);
        check(p1_o == 4'(ep), "R3", "P1", p1_o, ep);
        check(dot_khz_o == 24'(edot), "R1", "dot", dot_khz_o, edot);
        check(ok_o == eok, "R4", "ok", ok_o, eok);
        check(bad_sel_o == !evalid, "R7", "bad_sel", bad_sel_o, !evalid);
        exp_div = (em >= 10) ? (longint'(code_of(em)) << 8) : 0;
        exp_ctl = (ep >= 2) ? (longint'(1) << (17 + ep - 2)) : 0;
        check(div_word_o == 32'(exp_div), "R5", "div word", div_word_o, exp_div);
        check(ctl_word_o == 32'(exp_ctl), "R6", "ctl word", ctl_word_o, exp_ctl);
        repeat (3) @(negedge clk);
        check(done_o && m_o == 6'(em) && p1_o == 4'(ep) && dot_khz_o == 24'(edot) && ok_o == eok,
              "R9", "held result", longint'({m_o, p1_o}), longint'({6'(em), 4'(ep)}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int mhz_set[3] = '{100, 166, 200};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check(!busy_o && !done_o && !ok_o && !bad_sel_o, "R10", "flags after reset",
              longint'({busy_o, done_o, ok_o, bad_sel_o}), 0);
        check(m_o == 0 && p1_o == 0 && dot_khz_o == 0 && div_word_o == 0 && ctl_word_o == 0,
              "R10", "results after reset", longint'(dot_khz_o), 0);

        run_case(71428, 100, 1'b0);   // R1 exact hit, first candidate
        run_case(35714, 100, 1'b0);   // R3 tie: M20/P4 and M30/P6 give the same frequency
        run_case(0, 200, 1'b0);       // R4 no improvement
        run_case(1, 166, 1'b0);       // R4 no improvement
        run_case(1000000, 100, 1'b0); // R2 top of range wins
        run_case(50, 50, 1'b0);       // R7 unsupported
        run_case(60000, 0, 1'b0);     // R7 unsupported
        run_case(60000, 166, 1'b0);   // R5 codes for core 166
        run_case(90000, 200, 1'b1);   // R8 start during walk ignored
        run_case(40000, 255, 1'b0);   // R7 unsupported after valid run

        void'($urandom(32'd4242));
        for (int i = 0; i < 40; i++) begin
            run_case(int'($urandom_range(160000, 0)), mhz_set[$urandom_range(2, 0)], 1'b0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule